// File: doc/BRIEF.md
# Passive Serial Configuration Host Controller

This block sits on the host side of a passive serial configuration link. It loads a bitstream into a target FPGA. On a `start` pulse it holds the active-low request line `cfg_req_n` low for a fixed time and then releases it. It then waits for the target to release its status line. After that it shifts bytes from a valid/ready stream onto a single data pin, `data0`, and drives a serial clock, `dclk`, divided down from the system clock.

The target reports trouble by pulling its status line low. The controller aborts the load in that case. It retries in one of two ways:
- With `auto_restart` set, it waits for the target to release status by itself and sends no new request pulse.
- Otherwise, it issues a fresh request pulse.

After the last bit, the controller waits a bounded time for both `done_in` and `init_done_in`. If either is missing, that counts as an error and forces a restart. A retry limit ends in a sticky failure flag, and success raises a sticky OK flag.

Each new load attempt is announced by a one-cycle `rewind` pulse, so the byte source restarts from byte 0. The three target inputs pass through two-flop synchronizers.

Top module: `ps_cfg_host`

## Requirements
- R1: Every request pulse holds `cfg_req_n` low for exactly REQ_CYC = ceil(CLK_KHZ*REQ_US/1000) system cycles, then drives it high.
- R2: `dclk` never rises while `cfg_req_n` is low, nor before the target status input has been seen high after the request pulse.
- R3: Each accepted byte (`s_valid && s_ready`) is sent least-significant bit first. `data0` changes only while `dclk` is low and is stable across each rising edge. `dclk` spends DIV cycles low and DIV cycles high per bit. `rewind` pulses for one cycle just before each load attempt, and that attempt starts at byte 0.
- R4: When no valid byte is offered, `dclk` stays low for as long as the stall lasts, and the load then continues without an abort.
- R5: A low status during loading aborts the transfer: no further `dclk` rising edge occurs beyond the synchronizer latency.
- R6: With `auto_restart` high, after a status-low abort the controller waits for status to go high and reloads from byte 0 with no new request pulse.
- R7: With `auto_restart` high, if status stays low for TMO_CYC = ceil(CLK_KHZ*TMO_US/1000) cycles after an abort, the controller falls back to a request pulse.
- R8: With `auto_restart` low, a status-low abort is followed by a new request pulse.
- R9: After the last bit of `total_bytes` bytes, `cfg_ok` rises once both `done_in` and `init_done_in` are seen high. If they are not both high within FIN_CYC cycles, this is an error and a request pulse follows.
- R10: Errors are retried up to MAX_RETRY times. The next error sets `cfg_err`, so a load that never completes sees MAX_RETRY+1 request pulses. `cfg_ok` and `cfg_err` are never high together, and a new `start` clears both.
- R11: Whenever `cfg_ok` or `cfg_err` is high, `dclk` and `data0` are driven low.
- R12: After reset, `cfg_req_n`=1, `dclk`=0, `data0`=0, `s_ready`=0, and `busy`, `cfg_ok` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration (taken when not busy) |
| auto_restart | input | 1 | 1: target releases status by itself after an error |
| total_bytes | input | LEN_W | Bitstream length in bytes (at least 1) |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Byte on `s_data` is valid |
| s_ready | output | 1 | Controller takes the byte this cycle |
| rewind | output | 1 | One-cycle pulse: restart the byte stream at byte 0 |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| status_in | input | 1 | Target status, low means reset or error |
| done_in | input | 1 | Target configuration-done |
| init_done_in | input | 1 | Target initialization-done |
| dclk | output | 1 | Serial configuration clock |
| data0 | output | 1 | Serial configuration data |
| busy | output | 1 | A configuration is in progress |
| cfg_ok | output | 1 | Sticky success flag |
| cfg_err | output | 1 | Sticky failure flag |

## Verification
A wrong controller state shows at the pins within a bit time:
- A stray `dclk` rise while status is low is seen by the bench's target model at the next system cycle.
- A bit order or phase fault corrupts the byte image the target collects.
- A wrong recovery path changes the number and width of request pulses, and the bench counts those at every release.

Retry counting errors are visible only at the end of a run, as a wrong final flag or a wrong pulse count.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_LOAD,
    ST_FIN,
    ST_AUTO,
    ST_OK,
    ST_FAIL
  } ps_state_t;

  // microseconds to system cycles, rounded up
  function automatic int unsigned us_to_cycles(input int unsigned khz,
                                               input int unsigned us);
    return (khz * us + 999) / 1000;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ps_sync.sv
module ps_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/ps_shifter.sv
module ps_shifter #(
  parameter int unsigned DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  output logic       s_ready,
  output logic       dclk,
  output logic       data0,
  output logic       byte_done
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [7:0]    sh;
  logic          have;
  logic [2:0]    bcnt;
  logic [DW-1:0] ph;
  logic          clk_q;

  assign s_ready = en && !have;
  assign dclk    = en && clk_q;
  assign data0   = en && have && sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      have      <= 1'b0;
      bcnt      <= '0;
      ph        <= '0;
      clk_q     <= 1'b0;
      byte_done <= 1'b0;
    end else if (!en) begin
      have      <= 1'b0;
      bcnt      <= '0;
      ph        <= '0;
      clk_q     <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!have) begin
        if (s_valid) begin
          sh   <= s_data;
          have <= 1'b1;
          ph   <= '0;
        end
      end else if (ph != DW'(DIV - 1)) begin
        ph <= ph + 1'b1;
      end else begin
        ph <= '0;
        if (!clk_q) begin
          clk_q <= 1'b1;
        end else begin
          clk_q <= 1'b0;
          sh    <= {1'b0, sh[7:1]};
          bcnt  <= bcnt + 1'b1;
          if (bcnt == 3'd7) begin
            have      <= 1'b0;
            byte_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host
  import ps_cfg_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 250000,
  parameter int unsigned REQ_US    = 2,
  parameter int unsigned TMO_US    = 500,
  parameter int unsigned DIV       = 4,
  parameter int unsigned FIN_CYC   = 64,
  parameter int unsigned MAX_RETRY = 3,
  parameter int unsigned LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             auto_restart,
  input  logic [LEN_W-1:0] total_bytes,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             rewind,
  output logic             cfg_req_n,
  input  logic             status_in,
  input  logic             done_in,
  input  logic             init_done_in,
  output logic             dclk,
  output logic             data0,
  output logic             busy,
  output logic             cfg_ok,
  output logic             cfg_err
);
  localparam int unsigned REQ_CYC = us_to_cycles(CLK_KHZ, REQ_US);
  localparam int unsigned TMO_CYC = us_to_cycles(CLK_KHZ, TMO_US);
  localparam int unsigned MAXC    = max3(REQ_CYC, TMO_CYC, FIN_CYC);
  localparam int unsigned TW      = $clog2(MAXC + 1);
  localparam int unsigned RW      = $clog2(MAX_RETRY + 1);

  ps_state_t st, nxt;
  logic [TW-1:0]    tmr;
  logic [RW-1:0]    retry_cnt;
  logic [LEN_W-1:0] bytes_sent;
  logic [2:0]       sync_q;
  logic             sta_s, don_s, ini_s;
  logic             byte_done, load_active, auto_wait;
  logic             req_end, tmo_hit, fin_hit, last_byte, err_evt, go_load, exhausted;

  ps_sync #(.W(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({status_in, done_in, init_done_in}),
    .q    (sync_q)
  );
  assign {sta_s, don_s, ini_s} = sync_q;

  assign load_active = (st == ST_LOAD);
  assign auto_wait   = (st == ST_AUTO);

  ps_shifter #(.DIV(DIV)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (load_active),
    .s_data   (s_data),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .dclk     (dclk),
    .data0    (data0),
    .byte_done(byte_done)
  );

  // named events for the checker
  assign req_end   = (tmr == TW'(REQ_CYC - 1));
  assign tmo_hit   = (tmr == TW'(TMO_CYC - 1));
  assign fin_hit   = (tmr == TW'(FIN_CYC - 1));
  assign last_byte = byte_done && (bytes_sent == LEN_W'(total_bytes - 1'b1));
  assign exhausted = (retry_cnt == RW'(MAX_RETRY));
  assign err_evt   = (load_active && !sta_s)
                   || ((st == ST_WAIT) && !sta_s && tmo_hit)
                   || ((st == ST_FIN) && !(don_s && ini_s) && fin_hit);
  assign go_load   = ((st == ST_WAIT) || auto_wait) && sta_s;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE, ST_OK, ST_FAIL: if (start) nxt = ST_REQ;
      ST_REQ:  if (req_end) nxt = ST_WAIT;
      ST_WAIT: if (go_load) nxt = ST_LOAD;
      ST_LOAD: if (sta_s && last_byte) nxt = ST_FIN;
      ST_FIN:  if (don_s && ini_s) nxt = ST_OK;
      ST_AUTO: begin
        if (go_load) nxt = ST_LOAD;
        else if (tmo_hit) nxt = ST_REQ;
      end
      default: nxt = ST_IDLE;
    endcase
    if (err_evt) begin
      if (exhausted) nxt = ST_FAIL;
      else if (load_active && auto_restart) nxt = ST_AUTO;
      else nxt = ST_REQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      tmr        <= '0;
      retry_cnt  <= '0;
      bytes_sent <= '0;
    end else begin
      st <= nxt;
      if (nxt != st) tmr <= '0;
      else if (tmr != TW'(MAXC)) tmr <= tmr + 1'b1;
      if ((st == ST_IDLE || st == ST_OK || st == ST_FAIL) && start) retry_cnt <= '0;
      else if (err_evt && !exhausted) retry_cnt <= retry_cnt + 1'b1;
      if (!load_active) bytes_sent <= '0;
      else if (byte_done) bytes_sent <= bytes_sent + 1'b1;
    end
  end

  assign cfg_req_n = (st != ST_REQ);
  assign rewind    = go_load;
  assign busy      = !(st == ST_IDLE || st == ST_OK || st == ST_FAIL);
  assign cfg_ok    = (st == ST_OK);
  assign cfg_err   = (st == ST_FAIL);
endmodule

// File: rtl/ps_cfg_host_chk.sv
module ps_cfg_host_chk #(
  parameter int unsigned REQ_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cfg_req_n,
  input logic dclk,
  input logic data0,
  input logic cfg_ok,
  input logic cfg_err,
  input logic sta_s,
  input logic load_active,
  input logic auto_wait
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (cfg_req_n) low_cnt <= '0;
    else if (low_cnt != 32'hffff_ffff) low_cnt <= low_cnt + 1'b1;
  end

  a_r1_req_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_req_n) |-> (low_cnt >= REQ_CYC));
  a_r2_no_clk_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> !dclk);
  a_r2_rise_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $past(sta_s));
  a_r3_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $stable(data0));
  a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (load_active && !sta_s) |=> !load_active);
  a_r6_no_req_in_auto: assert property (@(posedge clk) disable iff (!rst_n)
    auto_wait |-> cfg_req_n);
  a_r10_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err));
  a_r11_pins_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ok || cfg_err) |-> (!dclk && !data0));
endmodule

bind ps_cfg_host ps_cfg_host_chk #(.REQ_CYC(REQ_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_req_n  (cfg_req_n),
  .dclk       (dclk),
  .data0      (data0),
  .cfg_ok     (cfg_ok),
  .cfg_err    (cfg_err),
  .sta_s      (sta_s),
  .load_active(load_active),
  .auto_wait  (auto_wait)
);

// File: tb/tb_ps_cfg_host.sv
`timescale 1ns/1ps
module tb_ps_cfg_host;
  localparam int CLK_KHZ = 4000;
  localparam int REQ_US  = 2;
  localparam int TMO_US  = 500;
  localparam int NB      = 16;

  logic clk = 0, rst_n = 0, start = 0, auto_restart = 0;
  logic [15:0] total_bytes = 16'(NB);
  logic [7:0] s_data;
  logic s_valid, s_ready, rewind, cfg_req_n, dclk, data0, busy, cfg_ok, cfg_err;
  logic t_status, t_done, t_init;

  ps_cfg_host #(.CLK_KHZ(CLK_KHZ), .REQ_US(REQ_US), .TMO_US(TMO_US), .DIV(2),
                .FIN_CYC(40), .MAX_RETRY(2), .LEN_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .auto_restart(auto_restart),
    .total_bytes(total_bytes), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .rewind(rewind), .cfg_req_n(cfg_req_n), .status_in(t_status), .done_in(t_done),
    .init_done_in(t_init), .dclk(dclk), .data0(data0), .busy(busy),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err));

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] mem [NB];
  logic [7:0] rx  [NB];
  int ptr = 0, pause_at = -1, pause_left = 0;
  int pulses = 0, badw = 0, lowc = 0, viol = 0, stall_rises = 0;
  int inj_bit = -1, inj_len = 0, no_done = 0;
  bit inj_armed = 0;

  function automatic int exp_req();
    int p;
    p = CLK_KHZ * REQ_US / 1000;
    if (p * 1000 < CLK_KHZ * REQ_US) p = p + 1;
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int data_mismatch();
    int n = 0;
    for (int i = 0; i < NB; i++) if (rx[i] !== mem[i]) n++;
    return n;
  endfunction

  // byte source
  initial begin
    bit acc = 0;
    s_valid = 0; s_data = 0;
    forever begin
      @(negedge clk);
      if (acc) ptr++;
      acc = 0;
      if (rewind) ptr = 0;
      if (pause_at >= 0 && ptr == pause_at && pause_left > 0) begin
        pause_left--; s_valid = 0;
      end else begin
        s_valid = (ptr < NB) && ($urandom % 4 != 0);
        s_data  = mem[(ptr < NB) ? ptr : 0];
      end
      #1;
      acc = s_valid && s_ready;
    end
  end

  // target model
  initial begin
    bit pd = 0, preq = 1, rise, hold = 0;
    int low_left = 0, rel = 0, age = 0, rxbits = 0, dcnt = 0;
    t_status = 1; t_done = 0; t_init = 0;
    forever begin
      @(negedge clk);
      rise = dclk && !pd; pd = dclk;
      if (!cfg_req_n) begin
        lowc++; t_status = 0; t_done = 0; t_init = 0; rxbits = 0; dcnt = 0;
        low_left = 0; hold = 0; rel = 4; age = 100;
        if (rise) viol++;
      end else begin
        if (!preq) begin
          pulses++;
          if (lowc != exp_req()) badw++;
          lowc = 0;
        end
        if (!t_status) begin
          age++;
          if (rise && age > 4) viol++;
          if (hold) ;
          else if (low_left > 0) begin
            low_left--;
            if (low_left == 0) rel = 1;
          end else if (rel > 0) begin
            rel--;
            if (rel == 0) t_status = 1;
          end
        end else begin
          if (rise) begin
            rx[rxbits/8][rxbits%8] = data0;
            rxbits++;
            if (pause_left > 0 && pause_left < 240) stall_rises++;
            if (inj_armed && rxbits == inj_bit) begin
              inj_armed = 0; t_status = 0; age = 0; rxbits = 0;
              if (inj_len < 0) hold = 1; else low_left = inj_len;
            end
          end
          if (rxbits == NB*8 && no_done == 0) begin
            if (dcnt < 3) dcnt++;
            else begin t_done = 1; t_init = 1; end
          end
        end
      end
      preq = cfg_req_n;
    end
  end

  task automatic run_case(input bit auto, input int ib, input int il,
                          input int nd, input int pa);
    int n = 0;
    for (int i = 0; i < NB; i++) begin mem[i] = 8'($urandom); rx[i] = 8'hxx; end
    @(negedge clk);
    auto_restart = auto; inj_bit = ib; inj_len = il; inj_armed = (ib > 0);
    no_done = nd; pause_at = pa; pause_left = (pa >= 0) ? 300 : 0;
    pulses = 0; badw = 0; viol = 0; stall_rises = 0;
    start = 1; @(negedge clk); start = 0;
    while (!(cfg_ok || cfg_err) && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) chk("watchdog", 1, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h1c0f_fee5));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 cfg_req_n", cfg_req_n, 1);
    chk("R12 dclk/data0", {dclk, data0}, 0);
    chk("R12 flags", {busy, cfg_ok, cfg_err, s_ready}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // clean load with a long stall
    run_case(1, -1, 0, 0, 5);
    chk("R9 ok after clean load", {cfg_ok, cfg_err}, 2'b10);
    chk("R1 single pulse", pulses, 1);
    chk("R1 pulse width", badw, 0);
    chk("R2 no early clock", viol, 0);
    chk("R3 data LSB first", data_mismatch(), 0);
    chk("R4 clock held during stall", stall_rises, 0);
    chk("R11 pins parked", {dclk, data0}, 0);

    // auto restart, short status pulse
    run_case(1, $urandom_range(9, NB*8-9), 60, 0, -1);
    chk("R6 ok after auto retry", cfg_ok, 1);
    chk("R6 no extra pulse", pulses, 1);
    chk("R5 abort stops clock", viol, 0);
    chk("R3 reload from byte 0", data_mismatch(), 0);

    // manual recovery
    run_case(0, $urandom_range(9, NB*8-9), -1, 0, -1);
    chk("R8 ok after pulse retry", cfg_ok, 1);
    chk("R8 second pulse", pulses, 2);
    chk("R1 width on retry", badw, 0);
    chk("R8 data", data_mismatch(), 0);

    // status stuck low past the time-out in auto mode
    run_case(1, 20, 3000, 0, -1);
    chk("R7 fallback pulse", pulses, 2);
    chk("R7 ok", cfg_ok, 1);

    // done never arrives
    run_case(1, -1, 0, 1, -1);
    chk("R10 error flag", {cfg_ok, cfg_err}, 2'b01);
    chk("R9 restart per missing done", pulses, 3);
    chk("R11 pins parked on fail", {dclk, data0}, 0);

    // new start clears failure
    run_case(0, -1, 0, 0, -1);
    chk("R10 flags cleared by start", {cfg_ok, cfg_err}, 2'b10);
    chk("R3 data after fail", data_mismatch(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule